// File: doc/BRIEF.md
# Resumable NMI Control Register Bank

This block holds the machine-level control registers that back resumable non-maskable interrupts. It has four software-visible registers: a scratch word, a saved exception PC, a saved cause and a status word. The status word carries the NMI-enable flag, the previous privilege level and the previous virtualization flag. Software reaches the bank through a simple register port with address, read strobe, write strobe, write data, read data and an illegal-access flag. Trap logic uses dedicated hardware ports to store the saved PC and cause and to clear the enable flag.

Two inputs change what the bank accepts. When the extension-enable input is low, every access to the bank is refused. When the hypervisor-present input is low, the previous-virtualization flag cannot be written. The bank exports the status fields and a one-cycle TLB flush request. It also holds a pending vector of resumable-NMI sources, which is set and cleared per bit by hardware.

Top module: `rnmi_csr_bank`

## Requirements
- R1: The scratch register (address 0x740) and the exception-PC register (address 0x741) each store a full XLEN-bit write. Read data for an enabled access appears combinationally in the same cycle as the read strobe.
- R2: The cause register (address 0x742) stores every write, from software or from hardware, with bit XLEN-1 forced to 0. Reads never return that bit set.
- R3: The status register is at address 0x744. NMI-enable is bit 3, previous-virtualization is bit 7 and previous-privilege is bits 12:11. Every other bit reads as 0.
- R4: A software status write with bit 3 high sets NMI-enable. A software status write with bit 3 low leaves NMI-enable unchanged.
- R5: A software status write updates previous-virtualization only while hypervisor-present is high. Otherwise the flag keeps its value. Previous-privilege is always written.
- R6: `tlbFlushReq` is high for exactly the one cycle that follows a status write made while hypervisor-present is high and changing previous-virtualization. It stays low in every other case.
- R7: While extension-enable is low, a read or write to any of the four bank addresses raises `csrIllegal` in the same cycle. Read data is 0 and no register changes.
- R8: An address outside the four bank addresses, including 0x743, never raises `csrIllegal`. It returns 0 read data and changes no register.
- R9: `hwNmieClr` clears NMI-enable and wins over a software status write in the same cycle that sets it.
- R10: `hwEpcWe` and `hwCauseWe` load the exception-PC and cause registers. Each takes priority over a software write to the same register in the same cycle.
- R11: On each clock, the pending vector becomes (pending AND NOT `pendClr`) OR `pendSet`.
- R12: Reset clears the pending vector, NMI-enable, the other status fields, all data registers and the flush request.
- R13: `csrRdata` is 0 whenever `csrRe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extEn | input | 1 | Extension enable; low refuses all bank accesses |
| hypPresent | input | 1 | Hypervisor present; gates the previous-virtualization flag |
| csrAddr | input | 12 | Register address |
| csrRe | input | 1 | Read strobe |
| csrWe | input | 1 | Write strobe |
| csrWdata | input | XLEN | Software write data |
| csrRdata | output | XLEN | Read data, same cycle |
| csrIllegal | output | 1 | Refused access to a bank address |
| hwEpcWe | input | 1 | Hardware load of the exception PC |
| hwEpc | input | XLEN | Hardware exception PC value |
| hwCauseWe | input | 1 | Hardware load of the cause |
| hwCause | input | XLEN | Hardware cause value |
| hwNmieClr | input | 1 | Hardware clear of NMI-enable |
| pendSet | input | PEND_W | Per-source pending set |
| pendClr | input | PEND_W | Per-source pending clear |
| nmiEnable | output | 1 | NMI-enable flag |
| prevPriv | output | 2 | Previous privilege field |
| prevVirt | output | 1 | Previous virtualization flag |
| tlbFlushReq | output | 1 | One-cycle TLB flush request |
| rnmiPending | output | PEND_W | Pending resumable-NMI vector |

## Verification
The bench builds the bank with XLEN of 32 and four pending sources. At that width the cause register's top bit is bit 31, so a write of 0x8000000B shows directly whether the top bit is masked. Four pending bits are enough for set, clear and a simultaneous set-and-clear on different bits in one vector. The hypervisor-present input is toggled within the vector walk, so the same status write can be checked both with and without the virtualization flag being writable.

// File: rtl/rnmi_csr_pkg.sv
package rnmi_csr_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] ADDR_SCRATCH = 12'h740;
  localparam logic [ADDR_W-1:0] ADDR_EPC     = 12'h741;
  localparam logic [ADDR_W-1:0] ADDR_CAUSE   = 12'h742;
  localparam logic [ADDR_W-1:0] ADDR_STATUS  = 12'h744;
  localparam int NMIE_BIT = 3;
  localparam int PV_BIT   = 7;
  localparam int PP_LO    = 11;
  localparam int PP_HI    = 12;
  localparam int NUM_REGS = 4;

  typedef enum logic [1:0] {
    SEL_SCRATCH = 2'd0,
    SEL_EPC     = 2'd1,
    SEL_CAUSE   = 2'd2,
    SEL_STATUS  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrOne;
    logic                rdOn;
    regSel_e             rdSel;
  } strobes_t;
endpackage

// File: rtl/rnmi_csr_ctrl.sv
module rnmi_csr_ctrl
  import rnmi_csr_pkg::*;
(
  input  logic              extEn,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrRe,
  input  logic              csrWe,
  output strobes_t          strobes,
  output logic              csrIllegal
);
  localparam logic [NUM_REGS-1:0][ADDR_W-1:0] ADDR_TABLE =
    {ADDR_STATUS, ADDR_CAUSE, ADDR_EPC, ADDR_SCRATCH};

  logic [NUM_REGS-1:0] hitVec;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_dec
      assign hitVec[g] = (csrAddr == ADDR_TABLE[g]);
    end
  endgenerate

  logic inBank;
  assign inBank = |hitVec;

  always_comb begin
    strobes.wrOne = (csrWe && extEn) ? hitVec : '0;
    strobes.rdOn  = csrRe && extEn && inBank;
    strobes.rdSel = SEL_SCRATCH;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hitVec[i]) strobes.rdSel = regSel_e'(i);
    end
  end

  assign csrIllegal = (csrRe || csrWe) && inBank && !extEn;
endmodule

// File: rtl/rnmi_csr_dp.sv
module rnmi_csr_dp
  import rnmi_csr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic              hypPresent,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  input  logic              hwEpcWe,
  input  logic [XLEN-1:0]   hwEpc,
  input  logic              hwCauseWe,
  input  logic [XLEN-1:0]   hwCause,
  input  logic              hwNmieClr,
  input  logic [PEND_W-1:0] pendSet,
  input  logic [PEND_W-1:0] pendClr,
  output logic              nmiEnable,
  output logic [1:0]        prevPriv,
  output logic              prevVirt,
  output logic              tlbFlushReq,
  output logic [PEND_W-1:0] rnmiPending
);
  localparam logic [XLEN-1:0] CAUSE_MASK = {1'b0, {(XLEN-1){1'b1}}};

  logic [XLEN-1:0] scratchQ, epcQ, causeQ, statusView;
  logic wrStatus, pvChange;

  assign wrStatus = strobes.wrOne[SEL_STATUS];
  assign pvChange = wrStatus && hypPresent && (csrWdata[PV_BIT] != prevVirt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scratchQ    <= '0;
      epcQ        <= '0;
      causeQ      <= '0;
      nmiEnable   <= 1'b0;
      prevPriv    <= 2'b00;
      prevVirt    <= 1'b0;
      tlbFlushReq <= 1'b0;
      rnmiPending <= '0;
    end else begin
      if (strobes.wrOne[SEL_SCRATCH]) scratchQ <= csrWdata;

      if (hwEpcWe)                      epcQ <= hwEpc;
      else if (strobes.wrOne[SEL_EPC])  epcQ <= csrWdata;

      if (hwCauseWe)                      causeQ <= hwCause & CAUSE_MASK;
      else if (strobes.wrOne[SEL_CAUSE])  causeQ <= csrWdata & CAUSE_MASK;

      if (hwNmieClr)                              nmiEnable <= 1'b0;
      else if (wrStatus && csrWdata[NMIE_BIT])    nmiEnable <= 1'b1;

      if (wrStatus)               prevPriv <= csrWdata[PP_HI:PP_LO];
      if (wrStatus && hypPresent) prevVirt <= csrWdata[PV_BIT];

      tlbFlushReq <= pvChange;
      rnmiPending <= (rnmiPending & ~pendClr) | pendSet;
    end
  end

  always_comb begin
    statusView              = '0;
    statusView[NMIE_BIT]    = nmiEnable;
    statusView[PV_BIT]      = prevVirt;
    statusView[PP_HI:PP_LO] = prevPriv;
  end

  always_comb begin
    csrRdata = '0;
    if (strobes.rdOn) begin
      unique case (strobes.rdSel)
        SEL_SCRATCH: csrRdata = scratchQ;
        SEL_EPC:     csrRdata = epcQ;
        SEL_CAUSE:   csrRdata = causeQ;
        SEL_STATUS:  csrRdata = statusView;
      endcase
    end
  end
endmodule

// File: rtl/rnmi_csr_bank.sv
module rnmi_csr_bank
  import rnmi_csr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extEn,
  input  logic              hypPresent,
  input  logic [11:0]       csrAddr,
  input  logic              csrRe,
  input  logic              csrWe,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  output logic              csrIllegal,
  input  logic              hwEpcWe,
  input  logic [XLEN-1:0]   hwEpc,
  input  logic              hwCauseWe,
  input  logic [XLEN-1:0]   hwCause,
  input  logic              hwNmieClr,
  input  logic [PEND_W-1:0] pendSet,
  input  logic [PEND_W-1:0] pendClr,
  output logic              nmiEnable,
  output logic [1:0]        prevPriv,
  output logic              prevVirt,
  output logic              tlbFlushReq,
  output logic [PEND_W-1:0] rnmiPending
);
  strobes_t strobes;

  rnmi_csr_ctrl i_ctrl (
    .extEn(extEn), .csrAddr(csrAddr), .csrRe(csrRe), .csrWe(csrWe),
    .strobes(strobes), .csrIllegal(csrIllegal)
  );

  rnmi_csr_dp #(.XLEN(XLEN), .PEND_W(PEND_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hypPresent(hypPresent),
    .csrWdata(csrWdata), .csrRdata(csrRdata),
    .hwEpcWe(hwEpcWe), .hwEpc(hwEpc), .hwCauseWe(hwCauseWe), .hwCause(hwCause),
    .hwNmieClr(hwNmieClr), .pendSet(pendSet), .pendClr(pendClr),
    .nmiEnable(nmiEnable), .prevPriv(prevPriv), .prevVirt(prevVirt),
    .tlbFlushReq(tlbFlushReq), .rnmiPending(rnmiPending)
  );
endmodule

// File: rtl/rnmi_csr_chk.sv
module rnmi_csr_chk #(
  parameter int XLEN   = 32,
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              extEn,
  input logic              hypPresent,
  input logic [11:0]       csrAddr,
  input logic              csrRe,
  input logic              csrWe,
  input logic [XLEN-1:0]   csrRdata,
  input logic              csrIllegal,
  input logic              hwNmieClr,
  input logic              nmiEnable,
  input logic              prevVirt,
  input logic              tlbFlushReq
);
  // R4
  nmie_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nmiEnable && !hwNmieClr) |=> nmiEnable);

  // R9
  nmie_hw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    hwNmieClr |=> !nmiEnable);

  // R5
  virt_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hypPresent |=> $stable(prevVirt));

  // R6
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    tlbFlushReq |-> ($past(hypPresent) && $past(csrWe) && !$stable(prevVirt)));

  // R7
  illegal_only_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    csrIllegal |-> (!extEn && csrRdata == '0));

  // R2
  cause_top_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrRe && extEn && csrAddr == 12'h742) |-> !csrRdata[XLEN-1]);

  // R13
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csrRe |-> (csrRdata == '0));
endmodule

bind rnmi_csr_bank rnmi_csr_chk #(.XLEN(XLEN), .PEND_W(PEND_W)) i_chk (.*);

// File: tb/test_rnmi_csr_bank.sv
module test_rnmi_csr_bank;
  localparam int XLEN = 32;
  localparam int PEND_W = 4;
  localparam int NV = 8;

  logic clk = 1'b0, rstN = 1'b0, extEn = 1'b1, hypPresent = 1'b0;
  logic [11:0] csrAddr = '0;
  logic csrRe = 1'b0, csrWe = 1'b0;
  logic [XLEN-1:0] csrWdata = '0, csrRdata;
  logic csrIllegal;
  logic hwEpcWe = 1'b0, hwCauseWe = 1'b0, hwNmieClr = 1'b0;
  logic [XLEN-1:0] hwEpc = '0, hwCause = '0;
  logic [PEND_W-1:0] pendSet = '0, pendClr = '0, rnmiPending;
  logic nmiEnable, prevVirt, tlbFlushReq;
  logic [1:0] prevPriv;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rnmi_csr_bank #(.XLEN(XLEN), .PEND_W(PEND_W)) i_rnmi_csr_bank (.*);

  localparam logic [NV-1:0][11:0] V_ADDR =
    {12'h744, 12'h743, 12'h744, 12'h744, 12'h744, 12'h742, 12'h741, 12'h740};
  localparam logic [NV-1:0][31:0] V_DATA =
    {32'h0000_1000, 32'hFFFF_FFFF, 32'h0000_0080, 32'h0000_0000,
     32'hFFFF_FFFF, 32'h8000_000B, 32'h1234_5678, 32'hA5A5_0001};
  localparam logic [NV-1:0] V_HYP = 8'b1010_0000;
  localparam logic [NV-1:0][31:0] V_EXP =
    {32'h0000_1008, 32'h0000_0000, 32'h0000_0088, 32'h0000_0008,
     32'h0000_1808, 32'h0000_000B, 32'h1234_5678, 32'hA5A5_0001};
  localparam logic [NV-1:0] V_FLUSH = 8'b1010_0000;

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
    @(negedge clk);
    csrAddr = a; csrWdata = d; csrWe = 1'b1;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [XLEN-1:0] d);
    @(negedge clk);
    csrAddr = a; csrRe = 1'b1;
    #1 d = csrRdata;
    @(negedge clk);
    csrRe = 1'b0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] r;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 nmie", {31'b0, nmiEnable}, 0);
    check("R12 pending", {28'b0, rnmiPending}, 0);
    check("R12 flush", {31'b0, tlbFlushReq}, 0);
    rstN = 1'b1;
    rd(12'h744, r); check("R12 status", r, 0);
    // R13
    #1 check("R13 idle rdata", csrRdata, 0);

    for (int i = 0; i < NV; i++) begin
      hypPresent = V_HYP[i];
      wr(V_ADDR[i], V_DATA[i]);
      check($sformatf("R6 flush vec%0d", i), {31'b0, tlbFlushReq}, {31'b0, V_FLUSH[i]});
      rd(V_ADDR[i], r);
      check($sformatf("R1 R2 R3 R4 R5 R8 vec%0d", i), r, V_EXP[i]);
      check($sformatf("R8 illegal vec%0d", i), {31'b0, csrIllegal}, 0);
    end
    hypPresent = 1'b0;

    // R6 pulse lasts one cycle
    hypPresent = 1'b1;
    wr(12'h744, 32'h0000_0080);
    check("R6 pulse high", {31'b0, tlbFlushReq}, 1);
    @(negedge clk);
    check("R6 pulse low", {31'b0, tlbFlushReq}, 0);
    wr(12'h744, 32'h0000_0080);
    check("R6 no change no flush", {31'b0, tlbFlushReq}, 0);
    hypPresent = 1'b0;

    // R7 extension disabled
    extEn = 1'b0;
    @(negedge clk);
    csrAddr = 12'h740; csrWdata = 32'hDEAD_BEEF; csrWe = 1'b1;
    #1 check("R7 illegal on write", {31'b0, csrIllegal}, 1);
    @(negedge clk);
    csrWe = 1'b0; csrRe = 1'b1;
    #1 check("R7 illegal on read", {31'b0, csrIllegal}, 1);
    check("R7 read zero", csrRdata, 0);
    @(negedge clk);
    csrRe = 1'b0; csrAddr = 12'h743; csrRe = 1'b1;
    #1 check("R8 outside no illegal", {31'b0, csrIllegal}, 0);
    @(negedge clk);
    csrRe = 1'b0;
    extEn = 1'b1;
    rd(12'h740, r); check("R7 scratch kept", r, 32'hA5A5_0001);

    // R9 hardware clear wins
    @(negedge clk);
    csrAddr = 12'h744; csrWdata = 32'h0000_0008; csrWe = 1'b1; hwNmieClr = 1'b1;
    @(negedge clk);
    csrWe = 1'b0; hwNmieClr = 1'b0;
    check("R9 nmie cleared", {31'b0, nmiEnable}, 0);
    wr(12'h744, 32'h0000_0008);
    check("R4 nmie set", {31'b0, nmiEnable}, 1);

    // R10 hardware loads win
    @(negedge clk);
    csrAddr = 12'h741; csrWdata = 32'h1111_1111; csrWe = 1'b1;
    hwEpcWe = 1'b1; hwEpc = 32'h2222_2222;
    hwCauseWe = 1'b1; hwCause = 32'hC000_0005;
    @(negedge clk);
    csrWe = 1'b0; hwEpcWe = 1'b0; hwCauseWe = 1'b0;
    rd(12'h741, r); check("R10 hw epc", r, 32'h2222_2222);
    rd(12'h742, r); check("R10 R2 hw cause", r, 32'h4000_0005);

    // R11 pending
    @(negedge clk);
    pendSet = 4'b0101;
    @(negedge clk);
    pendSet = 4'b1000; pendClr = 4'b0001;
    check("R11 set", {28'b0, rnmiPending}, 32'h5);
    @(negedge clk);
    pendSet = '0; pendClr = '0;
    check("R11 set clr", {28'b0, rnmiPending}, 32'hC);

    // R12 reset again
    rstN = 1'b0;
    @(negedge clk);
    check("R12 pending reset", {28'b0, rnmiPending}, 0);
    check("R12 nmie reset", {31'b0, nmiEnable}, 0);
    rstN = 1'b1;
    rd(12'h741, r); check("R12 epc reset", r, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule